// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine

This block moves rectangles of bytes inside a byte-addressed frame memory. Software programs a handful of 32-bit parameter registers: where the rectangle starts in the source and in the destination, its size, the step between rows, a colour and a bit mask. It then writes a control word. The engine either paints the destination rectangle with a solid colour or copies the source rectangle onto it. It moves one byte per clock through a single-port synchronous memory with a read latency of one cycle.

Source and destination may overlap. Software picks a traversal order that never reads a byte after it has been overwritten. A control bit makes each row run from its highest address downward. In that mode the width field holds a negated value and the start addresses point at the last byte of a row. A negative 16-bit pitch makes the rows run from the bottom upward, with the start addresses pointing at the last row. A status word reports when the engine is running, and a one-cycle pulse marks completion.

Top module: `blit_engine`

## Requirements
- R1: After reset every register reads zero, the status word reads zero, `done` is low and the memory port is inactive (`mem_en` low).
- R2: Register byte offsets: source start 0x00, second source start 0x04, source pitch 0x08, destination start 0x0C, size 0x10, destination pitch 0x14, colour 0x18, bit mask 0x20, write mask 0x24, control 0x28, status 0x90. Each parameter and the control word read back the last value accepted. Unmapped offsets read zero.
- R3: A control write with bit 6 set starts a fill. Each destination byte at address A gets colour byte lane A[1:0] ANDed with bit mask byte lane A[1:0], where lane k is bits 8k+7:8k. One byte is written per clock, so a rectangle of N bytes keeps the engine busy N cycles.
- R4: A control write with bit 0 set and bit 6 clear starts a copy. Each byte is read from the source and written to the destination on the next cycle, which takes two cycles per byte. Bytes outside the destination rectangle are not changed.
- R5: The size register holds rows minus one in bits 31:16 and row length in bytes minus one in bits 15:0.
- R6: Control bit 7 selects descending addresses within a row. The low half of the size register then holds the two's-complement negation of (bytes minus one), and both start addresses name the last byte of the first row.
- R7: At the end of each row, bits 15:0 of the source pitch (0x08) and of the destination pitch (0x14), taken as signed values, are added to the row start addresses. A negative pitch with start addresses on the last row gives bottom-to-top order.
- R8: Status bit 7 (cannot accept a command) and bit 6 (operation running) are both set from the cycle after the starting control write until the operation ends. Both read zero when idle.
- R9: While an operation runs, writes to every parameter register and to the control word are ignored: values do not change and no second operation starts.
- R10: `done` is high for exactly one cycle, the cycle after the last byte is written. The status word already reads zero in that cycle.
- R11: A control write with bit 0 and bit 6 both clear is stored but starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write (read when low and `mem_en` high) |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid the cycle after the read |
| done | output | 1 | One-cycle completion pulse |

## Verification
The engine holds its internal state in row and column counters and in the running addresses. A miscount of either counter shows at the ports at once: `done` arrives early or late, so the measured busy length differs from N or 2N cycles. A wrong address step or pitch leaves visible damage in memory, either wrong bytes inside the rectangle or stray writes next to it. The bench compares every byte of the memory after each operation, so such damage is caught when that operation ends. A register that accepts a write while busy shows on readback right after `done`, and a false restart shows as status staying set after the pulse.

// File: rtl/blit_pkg.sv
package blit_pkg;
   // register byte offsets (software decodes these)
   localparam logic [7:0] OFS_SRC    = 8'h00;
   localparam logic [7:0] OFS_SRC2   = 8'h04;
   localparam logic [7:0] OFS_SPITCH = 8'h08;
   localparam logic [7:0] OFS_DST    = 8'h0C;
   localparam logic [7:0] OFS_SIZE   = 8'h10;
   localparam logic [7:0] OFS_DPITCH = 8'h14;
   localparam logic [7:0] OFS_COLOUR = 8'h18;
   localparam logic [7:0] OFS_BMASK  = 8'h20;
   localparam logic [7:0] OFS_WMASK  = 8'h24;
   localparam logic [7:0] OFS_CTRL   = 8'h28;
   localparam logic [7:0] OFS_STAT   = 8'h90;

   localparam int CTL_COPY = 0;
   localparam int CTL_FILL = 6;
   localparam int CTL_DESC = 7;
   localparam int ST_NOACC = 7;
   localparam int ST_RUN   = 6;

   typedef enum logic [1:0] {S_IDLE, S_FILL, S_RD, S_WR} seq_t;
endpackage

// File: rtl/blit_regs.sv
module blit_regs
   import blit_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [7:0]    addr,
   input  logic [DW-1:0] wdata,
   input  logic          busy,
   output logic [DW-1:0] src,
   output logic [DW-1:0] dst,
   output logic [DW-1:0] spitch,
   output logic [DW-1:0] dpitch,
   output logic [DW-1:0] size,
   output logic [DW-1:0] colour,
   output logic [DW-1:0] bmask,
   output logic [DW-1:0] rdata,
   output logic          go,
   output logic          go_fill,
   output logic          go_desc
);
   logic [DW-1:0] src2, wmask, ctrl;
   logic          accept;

   assign accept  = we && !busy;
   assign go      = accept && addr == OFS_CTRL && (wdata[CTL_COPY] || wdata[CTL_FILL]);
   assign go_fill = wdata[CTL_FILL];
   assign go_desc = wdata[CTL_DESC];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src <= '0; src2 <= '0; spitch <= '0; dst <= '0; size <= '0;
         dpitch <= '0; colour <= '0; bmask <= '0; wmask <= '0; ctrl <= '0;
      end else if (accept) begin
         case (addr)
            OFS_SRC:    src    <= wdata;
            OFS_SRC2:   src2   <= wdata;
            OFS_SPITCH: spitch <= wdata;
            OFS_DST:    dst    <= wdata;
            OFS_SIZE:   size   <= wdata;
            OFS_DPITCH: dpitch <= wdata;
            OFS_COLOUR: colour <= wdata;
            OFS_BMASK:  bmask  <= wdata;
            OFS_WMASK:  wmask  <= wdata;
            OFS_CTRL:   ctrl   <= wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         OFS_SRC:    rdata = src;
         OFS_SRC2:   rdata = src2;
         OFS_SPITCH: rdata = spitch;
         OFS_DST:    rdata = dst;
         OFS_SIZE:   rdata = size;
         OFS_DPITCH: rdata = dpitch;
         OFS_COLOUR: rdata = colour;
         OFS_BMASK:  rdata = bmask;
         OFS_WMASK:  rdata = wmask;
         OFS_CTRL:   rdata = ctrl;
         OFS_STAT: begin
            rdata[ST_NOACC] = busy;
            rdata[ST_RUN]   = busy;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/blit_walker.sv
module blit_walker #(
   parameter int AW = 16,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step,
   input  logic          desc,
   input  logic [AW-1:0] src0,
   input  logic [AW-1:0] dst0,
   input  logic [CW-1:0] spitch,
   input  logic [CW-1:0] dpitch,
   input  logic [CW-1:0] rows_m1,
   input  logic [CW-1:0] width_f,
   output logic [AW-1:0] src_a,
   output logic [AW-1:0] dst_a,
   output logic          last
);
   logic [AW-1:0]        row_s, row_d, sp_q, dp_q, sp_ext, dp_ext;
   logic [CW-1:0]        col, row, wid_q, wid_ld;
   logic                 desc_q;
   logic signed [31:0]   sp_w, dp_w;

   assign sp_w   = 32'($signed(spitch));
   assign dp_w   = 32'($signed(dpitch));
   assign sp_ext = sp_w[AW-1:0];
   assign dp_ext = dp_w[AW-1:0];
   assign wid_ld = desc ? (CW'(0) - width_f) : width_f;
   assign last   = (col == '0) && (row == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_s <= '0; row_d <= '0; src_a <= '0; dst_a <= '0;
         sp_q <= '0; dp_q <= '0; col <= '0; row <= '0; wid_q <= '0; desc_q <= 1'b0;
      end else if (load) begin
         row_s <= src0; src_a <= src0;
         row_d <= dst0; dst_a <= dst0;
         sp_q <= sp_ext; dp_q <= dp_ext;
         col <= wid_ld; wid_q <= wid_ld;
         row <= rows_m1; desc_q <= desc;
      end else if (step && !last) begin
         if (col == '0) begin
            row_s <= row_s + sp_q; src_a <= row_s + sp_q;
            row_d <= row_d + dp_q; dst_a <= row_d + dp_q;
            col   <= wid_q;
            row   <= row - 1'b1;
         end else begin
            src_a <= desc_q ? src_a - 1'b1 : src_a + 1'b1;
            dst_a <= desc_q ? dst_a - 1'b1 : dst_a + 1'b1;
            col   <= col - 1'b1;
         end
      end
   end
endmodule

// File: rtl/blit_seq.sv
module blit_seq
   import blit_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   input  logic go_fill,
   input  logic last,
   output seq_t state,
   output logic step,
   output logic busy,
   output logic done
);
   assign step = (state == S_FILL) || (state == S_WR);
   assign busy = (state != S_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_IDLE;
         done  <= 1'b0;
      end else begin
         done <= step && last;
         case (state)
            S_IDLE: if (go) state <= go_fill ? S_FILL : S_RD;
            S_FILL: if (last) state <= S_IDLE;
            S_RD:   state <= S_WR;
            S_WR:   state <= last ? S_IDLE : S_RD;
            default: state <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/blit_engine.sv
module blit_engine
   import blit_pkg::*;
#(
   parameter int AW       = 16,
   parameter bit LANE_SEL = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [7:0]    reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   output logic          mem_en,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [7:0]    mem_wdata,
   input  logic [7:0]    mem_rdata,
   output logic          done
);
   localparam int DW = 32;
   localparam int CW = DW / 2;

   if (AW < 8 || AW > DW) begin : g_bad_aw
      $error("blit_engine: AW must lie in 8..32");
   end

   logic [DW-1:0] src, dst, spitch, dpitch, size, colour, bmask;
   logic          go, go_fill, go_desc, busy, step, last, copy_run;
   logic [AW-1:0] src_a, dst_a;
   logic [7:0]    fill_byte;
   seq_t          state;
   logic [DW-1:0] dst_base;

   blit_regs #(.DW(DW)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .busy(busy), .src(src), .dst(dst), .spitch(spitch), .dpitch(dpitch),
      .size(size), .colour(colour), .bmask(bmask), .rdata(reg_rdata),
      .go(go), .go_fill(go_fill), .go_desc(go_desc)
   );

   blit_walker #(.AW(AW), .CW(CW)) u_walk (
      .clk(clk), .rst_n(rst_n), .load(go), .step(step), .desc(go_desc),
      .src0(src[AW-1:0]), .dst0(dst[AW-1:0]),
      .spitch(spitch[CW-1:0]), .dpitch(dpitch[CW-1:0]),
      .rows_m1(size[DW-1:CW]), .width_f(size[CW-1:0]),
      .src_a(src_a), .dst_a(dst_a), .last(last)
   );

   blit_seq u_seq (
      .clk(clk), .rst_n(rst_n), .go(go), .go_fill(go_fill), .last(last),
      .state(state), .step(step), .busy(busy), .done(done)
   );

   if (LANE_SEL) begin : g_lane
      logic [1:0] lane;
      assign lane      = dst_a[1:0];
      assign fill_byte = colour[8*lane +: 8] & bmask[8*lane +: 8];
   end else begin : g_low
      assign fill_byte = colour[7:0] & bmask[7:0];
   end

   assign copy_run  = (state == S_RD) || (state == S_WR);
   assign dst_base  = dst;
   assign mem_en    = busy;
   assign mem_we    = step;
   assign mem_addr  = (state == S_RD) ? src_a : dst_a;
   assign mem_wdata = (state == S_FILL) ? fill_byte : mem_rdata;
endmodule

// File: rtl/blit_engine_chk.sv
module blit_engine_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        reg_we,
   input logic [7:0]  reg_addr,
   input logic        mem_en,
   input logic        mem_we,
   input logic        done,
   input logic        busy,
   input logic        copy_run,
   input logic [31:0] dst_base
);
   p_we_has_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_en);

   p_access_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |-> busy);

   p_read_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (copy_run && mem_we) |-> $past(mem_en && !mem_we));

   p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   p_busy_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && reg_we && reg_addr == 8'h0C) |=> $stable(dst_base));
endmodule

bind blit_engine blit_engine_chk u_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
   .mem_en(mem_en), .mem_we(mem_we), .done(done), .busy(busy),
   .copy_run(copy_run), .dst_base(dst_base)
);

// File: tb/sim_blit_engine.sv
module sim_blit_engine;
   localparam int AW = 12;
   localparam int MSZ = 1 << AW;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [7:0]    reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          mem_en, mem_we, done;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_wdata;
   logic [7:0]    mem_rdata = '0;

   logic [7:0] mem  [MSZ];
   logic [7:0] expm [MSZ];

   int n_chk = 0;
   int n_bad = 0;

   blit_engine #(.AW(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_en(mem_en),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .done(done)
   );

   always @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) mem[mem_addr] <= mem_wdata;
         else        mem_rdata <= mem[mem_addr];
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wreg(input logic [7:0] a, input logic [31:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rreg(input logic [7:0] a, output logic [31:0] d);
      reg_addr = a; #1; d = reg_rdata;
   endtask

   task automatic wait_done(output int cyc);
      cyc = 0;
      while (!done && cyc < 5000) begin
         @(posedge clk); @(negedge clk); cyc++;
      end
      if (!done) chk(1'b0, "watchdog", cyc, 0);
   endtask

   task automatic preload();
      for (int i = 0; i < MSZ; i++) begin
         mem[i]  = 8'((i * 7) + 3);
         expm[i] = mem[i];
      end
   endtask

   task automatic cmp_mem(input string req);
      int bad = 0; int fa = 0;
      for (int i = 0; i < MSZ; i++)
         if (mem[i] !== expm[i]) begin
            if (bad == 0) fa = i;
            bad++;
         end
      chk(bad == 0, req, bad == 0 ? 0 : {fa, mem[fa]}, bad == 0 ? 0 : {fa, expm[fa]});
   endtask

   // expected copy: destination takes the original source bytes
   task automatic exp_copy(input int s, input int d, input int rows, input int bytes, input int p);
      logic [7:0] orig [MSZ];
      for (int i = 0; i < MSZ; i++) orig[i] = expm[i];
      for (int r = 0; r < rows; r++)
         for (int c = 0; c < bytes; c++)
            expm[d + r * p + c] = orig[s + r * p + c];
   endtask

   task automatic t_reset();
      logic [31:0] v;
      chk(done == 1'b0 && mem_en == 1'b0, "R1 port idle", {done, mem_en}, 0);
      rreg(8'h90, v); chk(v == 0, "R1 status", v, 0);
      rreg(8'h0C, v); chk(v == 0, "R1 dst reg", v, 0);
      rreg(8'h28, v); chk(v == 0, "R1 ctrl reg", v, 0);
   endtask

   task automatic t_regmap();
      logic [31:0] v;
      logic [7:0] offs [9] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h20, 8'h24};
      for (int i = 0; i < 9; i++) wreg(offs[i], 32'hA5000000 + 32'(i * 32'h10203));
      for (int i = 0; i < 9; i++) begin
         rreg(offs[i], v);
         chk(v == 32'hA5000000 + 32'(i * 32'h10203), "R2 readback", v, 32'hA5000000 + 32'(i * 32'h10203));
      end
      rreg(8'h40, v); chk(v == 0, "R2 unmapped", v, 0);
      wreg(8'h28, 32'h0000_0F02);   // R11: neither bit 0 nor bit 6
      rreg(8'h28, v); chk(v == 32'h0F02, "R11 ctrl stored", v, 32'h0F02);
      rreg(8'h90, v); chk(v == 0, "R11 no start", v, 0);
      @(posedge clk); @(negedge clk);
      chk(mem_en == 1'b0, "R11 no access", mem_en, 0);
   endtask

   task automatic t_fill_solid();
      int cyc; logic [31:0] v;
      preload();
      wreg(8'h0C, 32'h105); wreg(8'h14, 32'd16); wreg(8'h10, 32'h0002_0003);
      wreg(8'h18, 32'h5A5A5A5A); wreg(8'h20, 32'hFFFFFFFF);
      wreg(8'h28, 32'h840);
      rreg(8'h90, v); chk(v == 32'hC0, "R8 status running", v, 32'hC0);
      wait_done(cyc);
      chk(cyc == 12, "R3 fill cycles", cyc, 12);
      rreg(8'h90, v); chk(v == 0, "R10 status zero at done", v, 0);
      @(posedge clk); @(negedge clk);
      chk(done == 1'b0, "R10 done one cycle", done, 0);
      for (int r = 0; r < 3; r++) for (int c = 0; c < 4; c++) expm[32'h105 + r * 16 + c] = 8'h5A;
      cmp_mem("R3 R5 solid fill");
   endtask

   task automatic t_fill_lanes();
      int cyc; logic [31:0] col, msk;
      col = 32'h44332211; msk = 32'hF0FF0FFF;
      preload();
      wreg(8'h0C, 32'h202); wreg(8'h10, 32'h0000_0005);
      wreg(8'h18, col); wreg(8'h20, msk);
      wreg(8'h28, 32'h840);
      wait_done(cyc);
      for (int a = 32'h202; a < 32'h208; a++) expm[a] = col[8 * (a % 4) +: 8] & msk[8 * (a % 4) +: 8];
      cmp_mem("R3 lane and mask");
   endtask

   task automatic t_copy_fwd();
      int cyc;
      preload();
      wreg(8'h00, 32'h300); wreg(8'h0C, 32'h340);
      wreg(8'h08, 32'h0010_0010); wreg(8'h14, 32'd16); wreg(8'h10, 32'h0001_0007);
      wreg(8'h28, 32'h05);
      wait_done(cyc);
      chk(cyc == 32, "R4 copy cycles", cyc, 32);
      exp_copy(32'h300, 32'h340, 2, 8, 16);
      cmp_mem("R4 forward copy");
   endtask

   task automatic t_copy_right();
      int cyc;
      preload();
      // 3 rows of 8 bytes from 0x400 to 0x403; start at last byte of row
      wreg(8'h00, 32'h407); wreg(8'h0C, 32'h40A);
      wreg(8'h08, 32'h0010_0010); wreg(8'h14, 32'd16);
      wreg(8'h10, 32'h0002_FFF9);
      wreg(8'h28, 32'h85);
      wait_done(cyc);
      chk(cyc == 48, "R6 descending cycles", cyc, 48);
      exp_copy(32'h400, 32'h403, 3, 8, 16);
      cmp_mem("R6 overlap right copy");
   endtask

   task automatic t_copy_down();
      int cyc;
      preload();
      // 4 rows of 6 bytes from 0x500 to 0x520; start at last row, pitch -16
      wreg(8'h00, 32'h530); wreg(8'h0C, 32'h550);
      wreg(8'h08, 32'h0010_FFF0); wreg(8'h14, 32'h0000_FFF0);
      wreg(8'h10, 32'h0003_0005);
      wreg(8'h28, 32'h05);
      wait_done(cyc);
      chk(cyc == 48, "R7 bottom-up cycles", cyc, 48);
      exp_copy(32'h500, 32'h520, 4, 6, 16);
      cmp_mem("R7 overlap down copy");
   endtask

   task automatic t_busy_ignore();
      int cyc; logic [31:0] v;
      preload();
      wreg(8'h0C, 32'h600); wreg(8'h14, 32'd16); wreg(8'h10, 32'h0007_0007);
      wreg(8'h18, 32'h11111111); wreg(8'h20, 32'hFFFFFFFF);
      wreg(8'h28, 32'h840);
      wreg(8'h0C, 32'h700);
      wreg(8'h18, 32'h99999999);
      wreg(8'h28, 32'h840);
      wait_done(cyc);
      chk(cyc == 61, "R9 single run length", cyc, 61);
      rreg(8'h0C, v); chk(v == 32'h600, "R9 dst unchanged", v, 32'h600);
      rreg(8'h18, v); chk(v == 32'h11111111, "R9 colour unchanged", v, 32'h11111111);
      for (int k = 0; k < 4; k++) begin
         @(posedge clk); @(negedge clk);
         rreg(8'h90, v);
         chk(!done && v == 0, "R9 no restart", {done, v}, 0);
      end
      for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) expm[32'h600 + r * 16 + c] = 8'h11;
      cmp_mem("R9 memory after busy writes");
   endtask

   initial begin
      #1_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      preload();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regmap();
      t_fill_solid();
      t_fill_lanes();
      t_copy_fwd();
      t_copy_right();
      t_copy_down();
      t_busy_ignore();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule